// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an 8051-style processor core to off-chip code and data memory over a narrow multiplexed bus. An 8-bit shared port carries the low address byte first and the data byte after it. A second 8-bit port carries the high address byte. The block produces the address-latch pulse and three active-low strobes: one for code fetches, one for data reads and one for data writes.

The core issues one request at a time. A request is a code fetch, a data read or a data write. Fetches always use a full 16-bit address. A data access takes its address in one of two ways:

- **Pointer mode:** a 16-bit address.
- **Paged mode:** an 8-bit register value supplies the low byte and a page register supplies the high byte.

A configuration enable decides whether the high-byte port carries addresses. When the enable is off, that port passes the general-purpose output value and output enable through unchanged.

Each bus cycle starts with the same two clocks:

1. The address-latch pulse is high for one clock while the low byte is on the shared port.
2. The pulse drops for one clock so that an external latch captures the low byte on the falling edge.

The strobe phase follows. A fetch has a 2-clock strobe phase, so back-to-back fetches produce the address-latch pulse once every 4 oscillator clocks. A data access uses a longer strobe plus one recovery clock, for 8 clocks in total. A data access therefore takes the place of one fetch strobe, and one address-latch pulse is missing from the regular rhythm.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are all 1, `ad_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: Take the clock edge that accepts a request as the reference edge.
  - In the first clock after that edge, `ale` is 1 and the shared port drives the low address byte.
  - In the second clock, `ale` is 0 and the same byte is still driven, so an external latch captures it on the falling edge of `ale`.
- R3: The high address byte and the low address byte depend on the request type:
  - Fetch: `req_addr[15:8]` and `req_addr[7:0]`.
  - Data access with `req_paged`=0: `req_addr[15:8]` and `req_addr[7:0]`.
  - Data access with `req_paged`=1: `page_reg` and `req_reg`.
- R4: With `hi_en`=1, `hi_oe` is 1 and `hi_out` carries the high address byte of the current or most recent cycle. With `hi_en`=0, `hi_out` equals `gpio2_out` and `hi_oe` equals `gpio2_oe`.
- R5: A fetch (`req_kind`=2'b00) behaves as follows:
  - `psen_n` is low in clocks 3 and 4 after acceptance, with `rd_n` and `wr_n` high.
  - The shared port is released during the strobe.
  - Back-to-back fetches give one `ale` pulse every 4 clocks.
- R6: A data read (`req_kind`=2'b01) behaves as follows:
  - `rd_n` is low in clocks 3 to 7 after acceptance.
  - The shared port is released in clocks 3 to 8.
  - `rdata` takes the value of `ad_in` from the edge that ends the last low clock of `rd_n`.
- R7: A data write (`req_kind`=2'b10) behaves as follows:
  - `wr_n` is low in clocks 3 to 7 after acceptance.
  - The shared port drives `req_wdata` in clocks 3 to 8, so it is still valid when `wr_n` rises.
- R8: A data access occupies 8 clocks and has a single `ale` pulse. In a continuous stream, the `ale` pulses either side of a data access are 8 clocks apart, and the gaps between fetches stay at 4 clocks.
- R9: `done` is a one-clock pulse.
  - It comes in clock 5 after acceptance for a fetch and in clock 8 for a data access.
  - `rdata` is valid while `done` is high.
  - `req_ready` is 1 only when the block is idle, in the last strobe clock of a fetch, or in the recovery clock of a data access. A request presented at any other time is not taken.
- R10: At most one of `psen_n`, `rd_n` and `wr_n` is low in any clock. None of them is low while `ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write |
| req_paged | input | 1 | Data access uses register plus page instead of 16-bit pointer |
| req_addr | input | 16 | Fetch address or data pointer |
| req_reg | input | 8 | Low address byte in paged mode |
| page_reg | input | 8 | High address byte in paged mode |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge if valid |
| done | output | 1 | Cycle complete, read data valid |
| rdata | output | 8 | Data captured from the shared port |
| hi_en | input | 1 | High-byte port carries addresses |
| gpio2_out | input | 8 | General-purpose value for the high-byte port |
| gpio2_oe | input | 1 | General-purpose output enable for the high-byte port |
| ad_in | input | 8 | Shared port input from the pad |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| hi_out | output | 8 | High-byte port output value |
| hi_oe | output | 1 | High-byte port output enable |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions assume the following about the block's inputs:
- `req_kind` never takes the value 2'b11.
- `hi_en` and the general-purpose inputs change only between bus cycles.
- The external memory settles `ad_in` before the read strobe ends.

The bench meets these assumptions in three ways:
- It draws the kind from the three legal codes only.
- It changes the enable and general-purpose values only while presenting a new request to an idle block.
- It drives `ad_in` combinationally from its own model of the address latch and the high-byte port.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        K_FETCH = 2'b00,
        K_READ  = 2'b01,
        K_WRITE = 2'b10
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_HOLD,
        S_STRB,
        S_RCV
    } phase_e;

    typedef struct packed {
        kind_e             kind;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] wdata;
    } xfer_t;

    function automatic kind_e decode_kind(input logic [1:0] code);
        case (code)
            2'b00:   return K_FETCH;
            2'b01:   return K_READ;
            default: return K_WRITE;
        endcase
    endfunction
endpackage

// File: rtl/ebc_addr_sel.sv
module ebc_addr_sel
    import ebc_pkg::*;
(
    input  logic [1:0]        kind_code,
    input  logic              paged,
    input  logic [ADDR_W-1:0] addr16,
    input  logic [BYTE_W-1:0] reg8,
    input  logic [BYTE_W-1:0] page,
    input  logic [BYTE_W-1:0] wdata,
    output xfer_t             xfer
);
    kind_e kind;
    logic  use_page;

    always_comb begin
        kind       = decode_kind(kind_code);
        // fetches never use the paged form
        use_page   = paged && (kind != K_FETCH);
        xfer.kind  = kind;
        xfer.hi    = use_page ? page : addr16[ADDR_W-1:BYTE_W];
        xfer.lo    = use_page ? reg8 : addr16[BYTE_W-1:0];
        xfer.wdata = wdata;
    end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int unsigned FETCH_STRB = 2,
    parameter int unsigned DATA_STRB  = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  xfer_t  xfer_in,
    output logic   req_ready,
    output phase_e phase,
    output xfer_t  cur,
    output logic   capture,
    output logic   done
);
    localparam int unsigned MAX_STRB = (DATA_STRB > FETCH_STRB) ? DATA_STRB : FETCH_STRB;
    localparam int unsigned CNT_W    = $clog2(MAX_STRB) + 1;
    localparam logic [CNT_W-1:0] F_LAST = CNT_W'(FETCH_STRB - 1);
    localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_STRB - 1);

    logic [CNT_W-1:0] cnt;
    logic             strb_last;
    logic             cycle_end;
    logic             accept;

    always_comb begin
        strb_last = (phase == S_STRB) && (cnt == '0);
        cycle_end = (strb_last && cur.kind == K_FETCH) || (phase == S_RCV);
        req_ready = (phase == S_IDLE) || cycle_end;
        accept    = req_valid && req_ready;
        capture   = strb_last && (cur.kind != K_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= S_IDLE;
            cnt   <= '0;
            cur   <= '0;
            done  <= 1'b0;
        end else begin
            done <= strb_last;
            if (accept) begin
                phase <= S_ADDR;
                cur   <= xfer_in;
            end else begin
                case (phase)
                    S_ADDR: phase <= S_HOLD;
                    S_HOLD: begin
                        phase <= S_STRB;
                        cnt   <= (cur.kind == K_FETCH) ? F_LAST : D_LAST;
                    end
                    S_STRB: begin
                        if (cnt != '0)
                            cnt <= cnt - 1'b1;
                        else if (cur.kind == K_FETCH)
                            phase <= S_IDLE;
                        else
                            phase <= S_RCV;
                    end
                    S_RCV:   phase <= S_IDLE;
                    default: phase <= S_IDLE;
                endcase
            end
        end
    end

    // R9: completion is a single-clock pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: recovery clock only follows a strobe phase
    a_r8_rcv_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (phase == S_RCV) |-> $past(phase == S_STRB));

    // R9: no new request is taken while the address is on the bus
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == S_ADDR || phase == S_HOLD) |=> (phase != S_ADDR));
endmodule

// File: rtl/ebc_port.sv
module ebc_port
    import ebc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  xfer_t             cur,
    input  logic              capture,
    input  logic              hi_en,
    input  logic [BYTE_W-1:0] gpio_out,
    input  logic              gpio_oe,
    input  logic [BYTE_W-1:0] ad_in,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] hi_out,
    output logic              hi_oe,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = cur.lo;
        case (phase)
            S_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            S_HOLD: ad_oe = 1'b1;
            S_STRB: begin
                case (cur.kind)
                    K_FETCH: psen_n = 1'b0;
                    K_READ:  rd_n   = 1'b0;
                    default: begin
                        wr_n   = 1'b0;
                        ad_oe  = 1'b1;
                        ad_out = cur.wdata;
                    end
                endcase
            end
            S_RCV: begin
                if (cur.kind == K_WRITE) begin
                    ad_oe  = 1'b1;
                    ad_out = cur.wdata;
                end
            end
            default: ;
        endcase
        hi_out = hi_en ? cur.hi : gpio_out;
        hi_oe  = hi_en ? 1'b1   : gpio_oe;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (capture)
            rdata <= ad_in;
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    a_r10_ale_quiet: assert property (@(posedge clk) disable iff (rst)
        ale |-> (psen_n && rd_n && wr_n));

    a_r6_read_release: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    a_r7_write_drive: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    a_r2_latch_first: assert property (@(posedge clk) disable iff (rst)
        ($fell(psen_n) || $fell(rd_n) || $fell(wr_n)) |-> $past(ale, 2));
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int unsigned FETCH_STRB = 2,
    parameter int unsigned DATA_STRB  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_paged,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_reg,
    input  logic [BYTE_W-1:0] page_reg,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    input  logic              hi_en,
    input  logic [BYTE_W-1:0] gpio2_out,
    input  logic              gpio2_oe,
    input  logic [BYTE_W-1:0] ad_in,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] hi_out,
    output logic              hi_oe,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n
);
    xfer_t  xfer_in;
    xfer_t  cur;
    phase_e phase;
    logic   capture;

    ebc_addr_sel u_sel (
        .kind_code (req_kind),
        .paged     (req_paged),
        .addr16    (req_addr),
        .reg8      (req_reg),
        .page      (page_reg),
        .wdata     (req_wdata),
        .xfer      (xfer_in)
    );

    ebc_seq #(
        .FETCH_STRB (FETCH_STRB),
        .DATA_STRB  (DATA_STRB)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .xfer_in   (xfer_in),
        .req_ready (req_ready),
        .phase     (phase),
        .cur       (cur),
        .capture   (capture),
        .done      (done)
    );

    ebc_port u_port (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cur      (cur),
        .capture  (capture),
        .hi_en    (hi_en),
        .gpio_out (gpio2_out),
        .gpio_oe  (gpio2_oe),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .hi_out   (hi_out),
        .hi_oe    (hi_oe),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rdata    (rdata)
    );
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_paged = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_reg = '0, page_reg = '0, req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic        hi_en = 1'b1;
    logic [7:0]  gpio2_out = '0;
    logic        gpio2_oe = 1'b0;
    logic [7:0]  ad_in, ad_out, hi_out;
    logic        ad_oe, hi_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0]  lat_lo = '0;
    logic [7:0]  wcap = '0;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ext_bus_ctrl u0 (.*);

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // external latch and memory model
    always @(negedge ale) lat_lo = ad_out;
    always @(posedge wr_n) wcap = ad_out;
    assign ad_in = mem_fn({hi_out, lat_lo});

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one isolated request; intrude=1 presents a stray request while busy (R9)
    task automatic do_req(input logic [1:0] k, input logic pg, input logic [15:0] a,
                          input logic [7:0] rg, input logic [7:0] pr, input logic [7:0] wd,
                          input logic he, input logic [7:0] gv, input logic go,
                          input logic intrude);
        int s;
        logic [7:0] ehi, elo, eport;
        string tg;
        s   = (k == 2'b00) ? 2 : 5;
        tg  = (k == 2'b00) ? "R5" : (k == 2'b01) ? "R6" : "R7";
        ehi = (pg && k != 2'b00) ? pr : a[15:8];   // R3
        elo = (pg && k != 2'b00) ? rg : a[7:0];
        eport = he ? ehi : gv;
        @(negedge clk);
        req_kind = k; req_paged = pg; req_addr = a; req_reg = rg; page_reg = pr;
        req_wdata = wd; hi_en = he; gpio2_out = gv; gpio2_oe = go; req_valid = 1'b1;
        chk("R9 ready idle", {15'd0, req_ready}, 16'd1);
        for (int i = 1; i <= s + 4; i++) begin
            logic e_ale, e_ps, e_rd, e_wr, e_oe, e_done, e_rdy, strb;
            logic [7:0] e_ad;
            @(negedge clk);
            if (i == 1) begin
                req_valid = intrude;
                if (intrude) begin req_kind = 2'b00; req_addr = ~a; end
            end
            if (i == 3) req_valid = 1'b0;
            strb  = (i >= 3) && (i <= s + 2);
            e_ale = (i == 1);
            e_ps  = !(strb && k == 2'b00);
            e_rd  = !(strb && k == 2'b01);
            e_wr  = !(strb && k == 2'b10);
            e_oe  = (i <= 2) || (k == 2'b10 && i <= s + 3);
            e_ad  = (i <= 2) ? elo : wd;
            e_done = (i == s + 3);
            e_rdy  = (i >= s + 3) || (k == 2'b00 && i == s + 2);
            chk({tg, " bus pins"}, {11'd0, e_ale, e_ps, e_rd, e_wr, e_oe} ^ 16'd0,
                {11'd0, e_ale, e_ps, e_rd, e_wr, e_oe});
            chk({tg, " pins ale/psen/rd/wr/oe"}, {11'd0, ale, psen_n, rd_n, wr_n, ad_oe},
                {11'd0, e_ale, e_ps, e_rd, e_wr, e_oe});
            if (e_oe) chk(i <= 2 ? "R2 low byte on port" : "R7 write data", {8'd0, ad_out}, {8'd0, e_ad});
            if (i <= s + 2) chk(he ? "R3 high byte" : "R4 gpio passthrough",
                                {7'd0, hi_oe, hi_out}, {7'd0, (he ? 1'b1 : go), eport});
            chk("R9 done/ready", {14'd0, done, req_ready}, {14'd0, e_done, e_rdy});
            if (i == 2) chk("R2 latched low byte", {8'd0, lat_lo}, {8'd0, elo});
            if (e_done && k != 2'b10) chk({tg, " rdata"}, {8'd0, rdata}, {8'd0, mem_fn({eport, elo})});
            if (e_done && k == 2'b10) chk("R7 write data at strobe rise", {8'd0, wcap}, {8'd0, wd});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset pins", {10'd0, ale, psen_n, rd_n, wr_n, ad_oe, done},
            {10'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
        chk("R1 ready", {15'd0, req_ready}, 16'd1);

        // directed corners
        do_req(2'b00, 1'b0, 16'h1234, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        do_req(2'b01, 1'b0, 16'hBEEF, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        do_req(2'b01, 1'b1, 16'hBEEF, 8'h77, 8'hC3, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        do_req(2'b10, 1'b1, 16'h0000, 8'h05, 8'h9A, 8'hE1, 1'b1, 8'h00, 1'b0, 1'b0);
        do_req(2'b00, 1'b1, 16'hA55A, 8'hFF, 8'h11, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0); // R3 fetch ignores paged
        do_req(2'b01, 1'b0, 16'h4321, 8'h00, 8'h00, 8'h00, 1'b0, 8'h6D, 1'b1, 1'b0); // R4
        do_req(2'b10, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h2B, 1'b0, 1'b0); // R4
        do_req(2'b01, 1'b0, 16'h0F0F, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1); // R9 stray request
        do_req(2'b10, 1'b0, 16'h8001, 8'h00, 8'h00, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b1); // R9

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [1:0] k;
            k = 2'($urandom_range(0, 2));
            do_req(k, 1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                   ($urandom_range(0, 3) != 0), 8'($urandom), 1'($urandom), 1'($urandom));
        end

        // R5 / R8: continuous stream F F F D F F, measure ALE spacing
        begin
            logic [1:0] kinds [6] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00};
            int exp_gap [5] = '{4, 4, 4, 8, 4};
            int gaps [5];
            int next = 0, last_ale = -1, g = 0, ps_clk = 0, rd_clk = 0;
            hi_en = 1'b1;
            for (int c = 0; c < 50; c++) begin
                @(negedge clk);
                if (ale) begin
                    if (last_ale >= 0 && g < 5) begin gaps[g] = c - last_ale; g++; end
                    last_ale = c;
                end
                if (!psen_n) ps_clk++;
                if (!rd_n) rd_clk++;
                if (req_ready) begin
                    if (next < 6) begin
                        req_valid = 1'b1; req_kind = kinds[next]; req_paged = 1'b0;
                        req_addr = 16'h2000 + 16'(next * 3);
                        next++;
                    end else req_valid = 1'b0;
                end
            end
            req_valid = 1'b0;
            chk("R8 ale gap count", g[15:0], 16'd5);
            for (int j = 0; j < 5; j++)
                chk(exp_gap[j] == 8 ? "R8 ale skipped around data" : "R5 ale every 4 clocks",
                    gaps[j][15:0], exp_gap[j][15:0]);
            chk("R5 psen low clocks", ps_clk[15:0], 16'd10);
            chk("R6 rd low clocks", rd_clk[15:0], 16'd5);
        end
        finish_up();
    end
endmodule